// File: doc/BRIEF.md
# Serial Debug Port Shift Register

This block is the serial front end of a processor debug port. A single shift register, 35 bits wide by default, takes bits one at a time from a debug data-in pin. It presents its most significant bit on a debug data-out pin. The same register works as the instruction register or the data register, depending on the operation code that the core presents when a transfer finishes. For a write to the trap-enable control register, the value is first built up in the shift register. When the transfer completes, its low bits are copied into the trap-enable register.

A clock-mode input picks the shift clock. In system-clock mode the debug clock pin acts as a synchronous shift qualifier: every system clock edge that sees it high causes one shift. In external-clock mode the debug clock and data-in pins pass through two-flop synchronizers, and one shift happens for each detected rising edge of the debug clock. After exactly as many shifts as the register is wide, a one-cycle completion strobe fires. At that point the received word goes to a parallel output, and a new parallel word from the core is loaded for the next shift-out. The top bit of that new word is replaced by the current freeze status.

The block also registers the core's debug-mode request onto a freeze output. While frozen, it forces the two-bit instruction-flush status outputs to 2'b11.

Top module: `dbg_shift_port`

## Requirements
- R1: Out of reset, dbg_dout_o, trap_ctl_o, freeze_o, flush_stat_o and xfer_done_o are all zero.
- R2: With ext_clk_mode_i=0, each system clock edge that samples dbg_clk_i high shifts the register left by one, taking dbg_din_i into bit 0. A cycle with dbg_clk_i low leaves dbg_dout_o unchanged.
- R3: With ext_clk_mode_i=1, exactly one shift happens per rising edge of dbg_clk_i after synchronization. Holding dbg_clk_i high for several cycles does not repeat the shift.
- R4: dbg_dout_o always shows the register's MSB. The word loaded at completion is shifted out most significant bit first. Its first bit is the freeze_o value at completion, followed by load_word_i[33:0] from bit 33 down to bit 0.
- R5: The SR_W-th shift after reset or after the previous completion raises xfer_done_o for exactly one cycle. In that cycle cap_word_o holds the received word, with the first bit received in bit SR_W-1.
- R6: cap_kind_o reports op_sel_i as sampled at completion. The encodings are 2'b00 instruction, 2'b01 data, 2'b10 trap-enable write and 2'b11 reserved.
- R7: When a transfer completes with op 2'b10, trap_ctl_o takes the low TRAP_W bits of the received word. trap_ctl_o keeps its value at any other time.
- R8: freeze_o follows freeze_req_i one system clock later.
- R9: flush_stat_o is 2'b11 while freeze_o is high. Otherwise it carries core_flush_i, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_mode_i | input | 1 | 1: shift on synchronized debug clock rising edges; 0: debug clock is a system-clock shift qualifier |
| dbg_clk_i | input | 1 | Debug clock / shift qualifier |
| dbg_din_i | input | 1 | Serial data in |
| dbg_dout_o | output | 1 | Serial data out (register MSB) |
| op_sel_i | input | 2 | Operation of the transfer in progress |
| load_word_i | input | 35 | Parallel word for the next shift-out |
| cap_word_o | output | 35 | Word received by the last transfer |
| cap_kind_o | output | 2 | Operation sampled at the last completion |
| xfer_done_o | output | 1 | One-cycle completion strobe |
| trap_ctl_o | output | 32 | Trap-enable control register |
| freeze_req_i | input | 1 | Core is in debug mode |
| core_flush_i | input | 2 | Core instruction-flush status |
| freeze_o | output | 1 | Registered freeze indication |
| flush_stat_o | output | 2 | Flush status outputs, 2'b11 in freeze |

## Verification
The bench targets an off-by-one bit count: a design with that error would raise the strobe early or late and misalign the captured word. It pauses the shift qualifier mid-word, so a design that shifts on every system clock loses its place. In external mode it holds the debug clock high across several system cycles, which would duplicate bits in a level-sensitive design. It also checks that only trap writes touch the trap register, that the reserved operation does not write it, and that the freeze bit leads the next shift-out rather than a stale load bit.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [1:0] {
    OP_INSTR = 2'b00,
    OP_DATA  = 2'b01,
    OP_TRAP  = 2'b10,
    OP_RSVD  = 2'b11
  } dsp_op_e;

  // flush status presented on the pins: frozen forces all ones
  function automatic logic [1:0] flush_view(input logic frozen, input logic [1:0] core_stat);
    return frozen ? 2'b11 : core_stat;
  endfunction

  // detected rising edge between a synchronized level and its previous sample
  function automatic logic rise_seen(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

endpackage

// File: rtl/dsp_sync.sv
module dsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dsp_shift_src.sv
module dsp_shift_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic dbg_clk,
  input  logic dbg_din,
  output logic shift_pulse,
  output logic shift_bit
);
  import dsp_pkg::*;

  logic clk_s, din_s, clk_prev;

  dsp_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(dbg_clk), .q(clk_s));
  dsp_sync #(.STAGES(SYNC_STAGES)) u_sync_din (
    .clk(clk), .rst_n(rst_n), .d(dbg_din), .q(din_s));

  always_ff @(posedge clk) begin
    if (!rst_n) clk_prev <= 1'b0;
    else        clk_prev <= clk_s;
  end

  always_comb begin
    if (ext_mode) begin
      shift_pulse = rise_seen(clk_s, clk_prev);
      shift_bit   = din_s;
    end else begin
      shift_pulse = dbg_clk;
      shift_bit   = dbg_din;
    end
  end
endmodule

// File: rtl/dsp_shift_core.sv
module dsp_shift_core #(
  parameter int SR_W   = 35,
  parameter int TRAP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_pulse,
  input  logic              shift_bit,
  input  logic              freeze_bit,
  input  logic [1:0]        op_sel,
  input  logic [SR_W-1:0]   load_word,
  output logic              dout,
  output logic [SR_W-1:0]   cap_word,
  output logic [1:0]        cap_kind,
  output logic              done,
  output logic [TRAP_W-1:0] trap_ctl,
  output logic              xfer_last
);
  import dsp_pkg::*;

  localparam int CNT_W = $clog2(SR_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SR_W - 1);

  logic [SR_W-1:0]  sr;
  logic [SR_W-1:0]  next_word;
  logic [CNT_W-1:0] cnt;

  assign next_word = {sr[SR_W-2:0], shift_bit};
  assign xfer_last = shift_pulse && (cnt == LAST_IDX);
  assign dout      = sr[SR_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      cap_word <= '0;
      cap_kind <= OP_INSTR;
      done     <= 1'b0;
      trap_ctl <= '0;
    end else begin
      done <= xfer_last;
      if (xfer_last) begin
        cap_word <= next_word;
        cap_kind <= op_sel;
        sr       <= {freeze_bit, load_word[SR_W-2:0]};
        cnt      <= '0;
        if (op_sel == OP_TRAP) trap_ctl <= next_word[TRAP_W-1:0];
      end else if (shift_pulse) begin
        sr  <= next_word;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dsp_freeze.sv
module dsp_freeze (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       freeze_req,
  input  logic [1:0] core_flush,
  output logic       freeze,
  output logic [1:0] flush_stat
);
  import dsp_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freeze     <= 1'b0;
      flush_stat <= 2'b00;
    end else begin
      freeze     <= freeze_req;
      flush_stat <= flush_view(freeze_req, core_flush);
    end
  end
endmodule

// File: rtl/dbg_shift_port.sv
module dbg_shift_port #(
  parameter int SR_W        = 35,
  parameter int TRAP_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_mode_i,
  input  logic              dbg_clk_i,
  input  logic              dbg_din_i,
  output logic              dbg_dout_o,
  input  logic [1:0]        op_sel_i,
  input  logic [SR_W-1:0]   load_word_i,
  output logic [SR_W-1:0]   cap_word_o,
  output logic [1:0]        cap_kind_o,
  output logic              xfer_done_o,
  output logic [TRAP_W-1:0] trap_ctl_o,
  input  logic              freeze_req_i,
  input  logic [1:0]        core_flush_i,
  output logic              freeze_o,
  output logic [1:0]        flush_stat_o
);
  logic shift_pulse, shift_bit, xfer_last;

  dsp_shift_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_clk_mode_i),
    .dbg_clk(dbg_clk_i), .dbg_din(dbg_din_i),
    .shift_pulse(shift_pulse), .shift_bit(shift_bit));

  dsp_shift_core #(.SR_W(SR_W), .TRAP_W(TRAP_W)) u_core (
    .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse), .shift_bit(shift_bit),
    .freeze_bit(freeze_o), .op_sel(op_sel_i), .load_word(load_word_i),
    .dout(dbg_dout_o), .cap_word(cap_word_o), .cap_kind(cap_kind_o),
    .done(xfer_done_o), .trap_ctl(trap_ctl_o), .xfer_last(xfer_last));

  dsp_freeze u_frz (
    .clk(clk), .rst_n(rst_n), .freeze_req(freeze_req_i), .core_flush(core_flush_i),
    .freeze(freeze_o), .flush_stat(flush_stat_o));
endmodule

// File: rtl/dbg_shift_port_chk.sv
module dbg_shift_port_chk #(
  parameter int TRAP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shift_pulse,
  input logic              xfer_last,
  input logic              dbg_dout_o,
  input logic              xfer_done_o,
  input logic [1:0]        cap_kind_o,
  input logic [TRAP_W-1:0] trap_ctl_o,
  input logic              freeze_req_i,
  input logic              freeze_o,
  input logic [1:0]        flush_stat_o
);
  assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(dbg_dout_o));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_done_o);

  assert_done_from_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |=> xfer_done_o);

  assert_trap_only_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trap_ctl_o) |-> (xfer_done_o && cap_kind_o == 2'b10));

  assert_freeze_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_req_i |=> freeze_o);

  assert_freeze_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_req_i |=> !freeze_o);

  assert_flush_forced_R9: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_o |-> flush_stat_o == 2'b11);
endmodule

bind dbg_shift_port dbg_shift_port_chk #(.TRAP_W(TRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .shift_pulse(shift_pulse), .xfer_last(xfer_last),
  .dbg_dout_o(dbg_dout_o), .xfer_done_o(xfer_done_o), .cap_kind_o(cap_kind_o),
  .trap_ctl_o(trap_ctl_o), .freeze_req_i(freeze_req_i), .freeze_o(freeze_o),
  .flush_stat_o(flush_stat_o));

// File: tb/dbg_shift_port_tb.sv
module dbg_shift_port_tb;
  localparam int W  = 35;
  localparam int TW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_mode = 1'b0, dclk = 1'b0, din = 1'b0;
  logic dout;
  logic [1:0] op = 2'b00;
  logic [W-1:0] load = '0;
  logic [W-1:0] cap;
  logic [1:0] kind;
  logic done;
  logic [TW-1:0] trap;
  logic frz_req = 1'b0;
  logic [1:0] cflush = 2'b01;
  logic frz;
  logic [1:0] fstat;

  int errors = 0, checks = 0, done_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dbg_shift_port u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_mode_i(ext_mode), .dbg_clk_i(dclk),
    .dbg_din_i(din), .dbg_dout_o(dout), .op_sel_i(op), .load_word_i(load),
    .cap_word_o(cap), .cap_kind_o(kind), .xfer_done_o(done), .trap_ctl_o(trap),
    .freeze_req_i(frz_req), .core_flush_i(cflush), .freeze_o(frz),
    .flush_stat_o(fstat));

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {op, freeze, word, load}
  localparam logic [72:0] VEC [4] = '{
    {2'b10, 1'b0, 35'h5_1234_5678, 35'h2_AAAA_5555},
    {2'b00, 1'b1, 35'h0_0000_0001, 35'h7_FFFF_FFFF},
    {2'b01, 1'b0, 35'h7_FFFF_FFFE, 35'h1_0F0F_F0F0},
    {2'b11, 1'b1, 35'h3_C3C3_C3C3, 35'h0_0000_0000}
  };

  initial begin
    logic [W-1:0] exp_out;
    logic [TW-1:0] exp_trap;
    logic [W-1:0] xw;
    exp_out = '0;
    exp_trap = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 dout", 64'(dout), 0);
    chk("R1 trap", 64'(trap), 0);
    chk("R1 freeze", 64'(frz), 0);
    chk("R1 flush", 64'(fstat), 0);
    chk("R1 done", 64'(done), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 4; v++) begin
      logic [1:0] vop;
      logic vfrz;
      logic [W-1:0] vword, vload;
      {vop, vfrz, vword, vload} = VEC[v];
      @(negedge clk);
      op = vop; frz_req = vfrz; load = vload;
      @(negedge clk);
      chk("R8 freeze", 64'(frz), 64'(vfrz));
      chk("R9 flush", 64'(fstat), vfrz ? 64'h3 : 64'h1);
      for (int i = W - 1; i >= 0; i--) begin
        if (i == 17) begin
          dclk = 1'b0;
          @(negedge clk);
          chk("R2 idle hold", 64'(dout), 64'(exp_out[i]));
          @(negedge clk);
        end
        dclk = 1'b1; din = vword[i];
        chk("R4 shift-out bit", 64'(dout), 64'(exp_out[i]));
        chk("R5 no early done", 64'(done), 0);
        @(negedge clk);
      end
      dclk = 1'b0;
      chk("R5 done", 64'(done), 1);
      chk("R5 cap word", 64'(cap), 64'(vword));
      chk("R6 kind", 64'(kind), 64'(vop));
      if (vop == 2'b10) exp_trap = vword[TW-1:0];
      chk("R7 trap", 64'(trap), 64'(exp_trap));
      @(negedge clk);
      chk("R5 done one cycle", 64'(done), 0);
      exp_out = {vfrz, vload[W-2:0]};
    end

    // R3 external clock mode
    ext_mode = 1'b1;
    op = 2'b10;
    xw = 35'h6_5A5A_3C3C;
    done_cnt = 0;
    repeat (4) @(negedge clk);
    for (int i = W - 1; i >= 0; i--) begin
      din = xw[i];
      repeat (4) @(negedge clk);
      dclk = 1'b1;
      repeat (5) @(negedge clk);
      dclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk("R3 one done per word", 64'(done_cnt), 1);
    chk("R3 ext cap", 64'(cap), 64'(xw));
    chk("R7 ext trap", 64'(trap), 64'(xw[TW-1:0]));
    chk("R4 ext first out is freeze", 64'(dout), 64'(1'b1));

    // R1 reset again
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 trap after reset", 64'(trap), 0);
    chk("R1 dout after reset", 64'(dout), 0);
    chk("R1 freeze after reset", 64'(frz), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule